// File: doc/BRIEF.md
# Divided One-Shot/Periodic Countdown Timer

This block is a local interrupt timer. Software programs a start value, a clock divider setting and a timer vector entry through a small register port. While armed, the counter steps down by one on every divided clock tick. When a step takes it from one to zero, the block records an expiry. In one-shot mode the counter then parks at zero. In periodic mode it reloads the start value and keeps counting.

Expiries accumulate in a saturating pending counter. The block raises an interrupt request carrying the programmed vector while the vector entry is unmasked and at least one expiry is pending. Each cycle in which the request is high and the acknowledge input is high consumes one pending expiry.

A level input gives the software-enable state. When it falls, the block forces the mask bit on and discards pending expiries.

Top module: `irq_countdown_timer`

Register map, selected by `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | vector entry | read/write |
| 1 | start value | read/write |
| 2 | live count | read-only |
| 3 | divider code | read/write, bits 3:0 |

## Requirements
- R1: After reset the vector entry reads 32'h0001_0000 (bit 16 set, so masked). The start value, live count and divider code all read 0, and `irq_req` is low.
- R2: The divider code `c` on bits 3:0 of address 3 selects a tick every 2^(({c[3],c[1],c[0]}+1) mod 8) clocks, and c[2] has no effect. For example, 4'b0000 gives 2, 4'b1010 gives 128 and 4'b1011 gives 1.
- R3: Writing address 1 with N>0 loads the live count with N in the cycle of the write, cancels any count in progress and restarts the divider. The first expiry then raises the request N×divisor cycles after the write edge.
- R4: A start value of 0 leaves the live count at 0, and no expiry ever follows.
- R5: In one-shot mode (bit 17 of the vector entry clear), the live count stays at 0 after an expiry until address 1 is written again.
- R6: In periodic mode (bit 17 set), the live count reloads the start value at the expiry edge and keeps counting.
- R7: Each expiry adds one to a pending count, which saturates at 2^PEND_W-1. `irq_req` is high exactly while bit 16 is clear and the pending count is nonzero, and `irq_vec` carries bits 7:0 of the vector entry. Each cycle with `irq_req` and `irq_ack` both high removes one pending expiry.
- R8: A write to the vector entry keeps only bits 7:0, 12, 16 and 17, and every other bit reads 0. A write to address 2 has no effect. The divider code keeps bits 3:0.
- R9: A falling edge on `sw_en` sets bit 16 and clears the pending count. A vector-entry write while `sw_en` is low stores bit 16 as 1.
- R10: While bit 16 is set, expiries still add to the pending count but `irq_req` stays low. Clearing bit 16 then raises the request.
- R11: A change of divider code during a count takes effect from the next divider tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_en | input | 1 | Software-enable level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector carried by the request |
| irq_ack | input | 1 | Request accepted in this cycle |

## Verification
The bench builds the block with PEND_W=2. This makes the pending count saturate at 3, so saturation and the full drain by acknowledges are reached after a handful of masked periodic expiries.

Divider codes 1011, 0000, 0100 and 1010 are all timed, including the largest divisor of 128, so the mapping and the ignored bit are exercised end to end. The bench also changes the divider code mid-count, restarts a count that is already running, and drops the software-enable level while an expiry is pending.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int REG_W       = 32;
  localparam int VEC_W       = 8;
  localparam int DIVCFG_W    = 4;
  localparam int SHIFT_W     = 3;
  localparam int MASK_BIT    = 16;
  localparam int PERIOD_BIT  = 17;
  localparam logic [REG_W-1:0] VEC_KEEP  = 32'h0003_10FF;
  localparam logic [REG_W-1:0] VEC_RESET = 32'h0001_0000;

  typedef enum logic [1:0] {
    A_VEC  = 2'd0,
    A_INIT = 2'd1,
    A_CUR  = 2'd2,
    A_DIV  = 2'd3
  } reg_addr_e;

  // divider exponent: bit 2 of the code is ignored, value wraps modulo 8
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIVCFG_W-1:0] code);
    logic [SHIFT_W-1:0] sel;
    sel = {code[3], code[1:0]};
    return sel + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_rst_sync.sv
`timescale 1ns/1ps
module cdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;
  localparam logic [PRE_W-1:0] ONES = '1;

  logic [PRE_W-1:0] cnt_q, cnt_d, lim;
  logic             cnt_en;

  always_comb begin
    lim    = ONES >> (PRE_W - int'(shift));
    tick   = run && !restart && (cnt_q >= lim);
    cnt_en = 1'b1;
    if (restart || !run || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && shift == '0) |-> tick);
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             act_q, act_d, cnt_en;

  always_comb begin
    cur_d  = cur_q;
    act_d  = act_q;
    expire = act_q && tick && !load && (cur_q == CNT_W'(1));
    cnt_en = load || (act_q && tick);
    if (load) begin
      cur_d = load_val;
      act_d = |load_val;
    end else if (expire) begin
      cur_d = periodic ? init_val : '0;
      act_d = periodic;
    end else if (act_q && tick) begin
      cur_d = cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cur_q <= cur_d;
      act_q <= act_d;
    end
  end

  assign cur    = cur_q;
  assign active = act_q;

  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !load) |=> $stable(cur_q));
  // R4
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (cur_q == '0 && !act_q));
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur_q == $past(init_val)));
endmodule

// File: rtl/cdt_pending.sv
`timescale 1ns/1ps
module cdt_pending #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic nonzero
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              dec_ok, pend_en;

  always_comb begin
    dec_ok  = dec && (pend_q != '0);
    pend_en = clr || inc || dec_ok;
    pend_d  = pend_q;
    if (clr)                  pend_d = '0;
    else if (inc && !dec_ok)  pend_d = (pend_q == PMAX) ? PMAX : pend_q + PEND_W'(1);
    else if (dec_ok && !inc)  pend_d = pend_q - PEND_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign nonzero = (pend_q != '0);

  // R7
  pend_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && !inc && !clr) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
  // R7
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !clr && pend_q == PMAX) |=> (pend_q == PMAX));
  // R9
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend_q == '0));
endmodule

// File: rtl/irq_countdown_timer.sv
`timescale 1ns/1ps
module irq_countdown_timer #(
  parameter int PEND_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vec,
  input  logic        irq_ack
);
  import cdt_pkg::*;

  logic                rst_n_s;
  logic [REG_W-1:0]    vec_q, vec_d, init_q, cur;
  logic [DIVCFG_W-1:0] div_q;
  logic                swen_q;
  logic                wr_vec, wr_init, wr_div, sw_fall, vec_en;
  logic                tick, active, expire, pend_nz;

  cdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  always_comb begin
    wr_vec  = reg_wr && (reg_addr == A_VEC);
    wr_init = reg_wr && (reg_addr == A_INIT);
    wr_div  = reg_wr && (reg_addr == A_DIV);
    sw_fall = swen_q && !sw_en;
    vec_en  = wr_vec || sw_fall;
    vec_d   = vec_q;
    if (wr_vec) begin
      vec_d = reg_wdata & VEC_KEEP;
      if (!sw_en) vec_d[MASK_BIT] = 1'b1;
    end else if (sw_fall) begin
      vec_d[MASK_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vec_q  <= VEC_RESET;
      init_q <= '0;
      div_q  <= '0;
      swen_q <= 1'b0;
    end else begin
      swen_q <= sw_en;
      if (vec_en)  vec_q  <= vec_d;
      if (wr_init) init_q <= reg_wdata;
      if (wr_div)  div_q  <= reg_wdata[DIVCFG_W-1:0];
    end
  end

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .restart(wr_init), .run(active),
    .shift(div_shift(div_q)), .tick(tick));

  cdt_counter #(.CNT_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(wr_init), .load_val(reg_wdata),
    .init_val(init_q), .tick(tick), .periodic(vec_q[PERIOD_BIT]),
    .cur(cur), .active(active), .expire(expire));

  cdt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n_s), .inc(expire), .dec(irq_req && irq_ack),
    .clr(sw_fall), .nonzero(pend_nz));

  assign irq_req = !vec_q[MASK_BIT] && pend_nz;
  assign irq_vec = vec_q[VEC_W-1:0];

  always_comb begin
    case (reg_addr)
      A_VEC:   reg_rdata = vec_q;
      A_INIT:  reg_rdata = init_q;
      A_CUR:   reg_rdata = cur;
      default: reg_rdata = {{(REG_W-DIVCFG_W){1'b0}}, div_q};
    endcase
  end

  // R9
  mask_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(sw_en) |=> vec_q[MASK_BIT]);
  // R8
  vec_fields_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_vec |=> ((vec_q & ~VEC_KEEP) == '0));
endmodule

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;
  localparam int PEND_W   = 2;
  localparam int PEND_MAX = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        irq_ack = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  irq_countdown_timer #(.PEND_W(PEND_W)) i_irq_countdown_timer (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack));

  always #2 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  // behavioural reference state
  logic [31:0] m_vec, m_init, m_cur;
  logic [3:0]  m_div;
  int          m_pre, m_pend;
  bit          m_act, m_swp;

  function automatic int divisor(input logic [3:0] c);
    int e;
    e = (int'({c[3], c[1:0]}) + 1) % 8;
    return 1 << e;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_vec;
      2'd1:    return m_init;
      2'd2:    return m_cur;
      default: return {28'd0, m_div};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit fell, acc, tk, ex;
    int d;
    if (!rst_n) begin
      m_vec = 32'h0001_0000; m_init = 0; m_cur = 0; m_div = 0;
      m_pre = 0; m_pend = 0; m_act = 0; m_swp = 0;
    end else begin
      fell = m_swp && !sw_en;
      acc  = !m_vec[16] && (m_pend != 0) && irq_ack;
      d    = divisor(m_div);
      tk   = 0; ex = 0;
      if (reg_wr && reg_addr == 2'd1) begin
        m_cur = reg_wdata; m_act = (reg_wdata != 0); m_pre = 0;
      end else if (m_act) begin
        if (m_pre >= d - 1) begin tk = 1; m_pre = 0; end
        else m_pre++;
        if (tk) begin
          if (m_cur == 1) begin
            ex = 1;
            if (m_vec[17]) m_cur = m_init;
            else begin m_cur = 0; m_act = 0; end
          end else m_cur = m_cur - 1;
        end
      end
      if (fell) m_pend = 0;
      else if (ex && !acc) m_pend = (m_pend < PEND_MAX) ? m_pend + 1 : PEND_MAX;
      else if (acc && !ex) m_pend--;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            m_vec = reg_wdata & 32'h0003_10FF;
            if (!sw_en) m_vec[16] = 1'b1;
          end
          2'd1: m_init = reg_wdata;
          2'd3: m_div = reg_wdata[3:0];
          default: ;
        endcase
      end
      if (fell) m_vec[16] = 1'b1;
      m_swp = sw_en;
    end
  end

  task automatic check(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, expv);
    end
  endtask

  // one clock, then compare every output against the reference
  task automatic cyc();
    @(negedge clk);
    check(tag, "irq_req", {31'd0, irq_req}, {31'd0, (!m_vec[16] && m_pend != 0)});
    check(tag, "irq_vec", {24'd0, irq_vec}, {24'd0, m_vec[7:0]});
    check(tag, "reg_rdata", reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a;
    cyc();
  endtask

  task automatic drain();
    irq_ack = 1'b1;
    for (int i = 0; i < 10 && irq_req; i++) cyc();
    irq_ack = 1'b0;
    cyc();
  endtask

  // write start value and count cycles until the request rises
  task automatic measure(input logic [31:0] n, input int expv, input string t);
    int k;
    wr(2'd1, n);
    reg_addr = 2'd2;
    k = 0;
    while (!irq_req && k < 2000) begin cyc(); k++; end
    check(t, "cycles to expiry", k, expv);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);

    tag = "R1";
    rd(2'd0); check("R1", "vector entry", reg_rdata, 32'h0001_0000);
    rd(2'd1); check("R1", "start value", reg_rdata, 32'd0);
    rd(2'd2); check("R1", "live count", reg_rdata, 32'd0);
    rd(2'd3); check("R1", "divider code", reg_rdata, 32'd0);
    check("R1", "irq_req", {31'd0, irq_req}, 32'd0);

    tag = "R8";
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0); check("R8", "vector field keep", reg_rdata, 32'h0003_10FF);
    wr(2'd3, 32'hFFFF_FFF5);
    rd(2'd3); check("R8", "divider keep", reg_rdata, 32'd5);

    tag = "R2";
    wr(2'd0, 32'h0000_0030);
    wr(2'd3, 32'h0000_000B);
    measure(32'd5, 5, "R2");
    check("R7", "irq_vec", {24'd0, irq_vec}, 32'h30);
    drain();
    wr(2'd3, 32'h0000_0000);
    measure(32'd3, 6, "R2");
    drain();
    wr(2'd3, 32'h0000_0004);
    measure(32'd4, 8, "R2");
    drain();
    wr(2'd3, 32'h0000_000A);
    measure(32'd2, 256, "R2");
    drain();

    tag = "R5";
    idle(20);
    rd(2'd2); check("R5", "one-shot parks at zero", reg_rdata, 32'd0);

    tag = "R3";
    wr(2'd3, 32'h0000_000B);
    wr(2'd1, 32'd100);
    reg_addr = 2'd2;
    idle(10);
    check("R3", "live count mid run", reg_rdata, 32'd90);
    wr(2'd2, 32'd55);
    check("R8", "live count write ignored", reg_rdata, 32'd89);
    measure(32'd7, 7, "R3");
    drain();

    tag = "R4";
    wr(2'd1, 32'd0);
    reg_addr = 2'd2;
    idle(50);
    check("R4", "live count zero", reg_rdata, 32'd0);
    check("R4", "no request", {31'd0, irq_req}, 32'd0);

    tag = "R11";
    wr(2'd3, 32'h0000_0000);
    wr(2'd1, 32'd10);
    idle(3);
    wr(2'd3, 32'h0000_000B);
    reg_addr = 2'd2;
    k = 0;
    while (!irq_req && k < 200) begin cyc(); k++; end
    check("R11", "cycles after divider change", k, 8);
    drain();

    tag = "R6";
    wr(2'd0, 32'h0002_0041);
    measure(32'd4, 4, "R6");
    check("R6", "reload at expiry", reg_rdata, 32'd4);
    irq_ack = 1'b1;
    idle(3);
    irq_ack = 1'b0;
    measure(32'd3, 3, "R6");
    k = 0;
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
    while (!irq_req && k < 50) begin cyc(); k++; end
    check("R6", "periodic interval", k, 2);

    tag = "R10";
    wr(2'd0, 32'h0003_0041);
    wr(2'd1, 32'd2);
    idle(20);
    check("R10", "masked no request", {31'd0, irq_req}, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0000_0041);
    check("R10", "unmask raises request", {31'd0, irq_req}, 32'd1);

    tag = "R7";
    k = 0;
    irq_ack = 1'b1;
    while (irq_req && k < 10) begin cyc(); k++; end
    irq_ack = 1'b0;
    check("R7", "saturated pending drains", k, PEND_MAX);

    tag = "R9";
    measure(32'd2, 2, "R9");
    sw_en = 1'b0;
    rd(2'd0);
    check("R9", "fall masks", {31'd0, reg_rdata[16]}, 32'd1);
    check("R9", "fall drops request", {31'd0, irq_req}, 32'd0);
    wr(2'd0, 32'h0000_0030);
    rd(2'd0); check("R9", "write while disabled masked", reg_rdata, 32'h0001_0030);
    sw_en = 1'b1;
    idle(2);
    wr(2'd0, 32'h0000_0030);
    idle(2);
    check("R9", "pending cleared", {31'd0, irq_req}, 32'd0);

    idle(4);
    finish_run();
  end
endmodule